// File: doc/BRIEF.md
# Data-Memory Address Unit

This unit sits between the control unit of a small 8-bit microcontroller core and its data RAM. It builds the RAM address, the read strobe and the write strobe, and it drives the outgoing write data. It also holds the file select register (FSR), which is the pointer register of the core.

Each access is a request from the control unit. A request carries the 5-bit file field of the current instruction, a read/write flag and, for a write, the data byte. Two addressing modes are available:

- **Direct mode.** The file field gives the low five address bits. The top three bits come from FSR[7:5], which act as bank bits.
- **Indirect mode.** A file field of zero selects this mode. The whole FSR is then used as the address.

A write whose effective address has low bits equal to 4 reaches the FSR, in any bank, and reloads it.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where `acc_valid` and `acc_ready` are both high. After an acceptance, `acc_ready` stays low for one cycle while the strobe is driven. During that cycle the requester must keep `acc_valid`, `acc_write`, `acc_file` and `acc_wdata` steady, or drop `acc_valid`. A request that is held is taken on the next edge where `acc_ready` is high. The RAM side has no back-pressure.

Top module: `dmem_addr_unit`

## Requirements
- R1: After reset, `ram_we`=0, `ram_oe`=0, `ram_addr`=0, `ram_wdata`=0, `acc_ready`=1, and the FSR holds 0x00.
- R2: For an accepted request with a non-zero `acc_file`, the address in the cycle after acceptance is {FSR[7:5], acc_file}, using the FSR value at acceptance.
- R3: For an accepted request with `acc_file`=0, the address in the cycle after acceptance equals the whole FSR value at acceptance.
- R4: An accepted read (`acc_write`=0) raises `ram_oe` for exactly the one cycle after acceptance, and `ram_we` stays low.
- R5: An accepted write (`acc_write`=1) raises `ram_we` for exactly the one cycle after acceptance, `ram_oe` stays low, and `ram_wdata` equals the accepted data.
- R6: `ram_we` and `ram_oe` are never high in the same cycle.
- R7: `acc_ready` is low in every cycle where a strobe is high, and a request is not accepted while `acc_ready` is low.
- R8: `ram_addr` and `ram_wdata` change only on an accepting edge, so they are steady through the strobe cycle and afterwards.
- R9: A write whose effective address has bits [4:0] = 4 loads the FSR with the written data at the end of its strobe cycle. The next accepted access uses the new value.
- R10: Reads, and writes to any other address, leave the FSR unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Unit can accept a request this edge |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_file | input | 5 | File field (low bits of the instruction word) |
| acc_wdata | input | 8 | Data byte for a write |
| ram_addr | output | 8 | Data RAM address |
| ram_wdata | output | 8 | Data RAM write data |
| ram_we | output | 1 | Data RAM write enable, one-cycle pulse |
| ram_oe | output | 1 | Data RAM output enable, one-cycle pulse |

## Verification
Some properties are checked by assertions on every cycle:
- the two strobes are exclusive and each lasts one cycle;
- `acc_ready` is low during a strobe;
- the address and data hold between acceptances;
- the direct and indirect address mapping holds against the FSR at acceptance;
- the FSR changes only on a strobe that hits it.

Other behaviour can only be shown by the bench's scenarios. These include the bank bits carried from an FSR write into the following access, and an indirect write through a pointer that aims at the FSR itself. They also include holding a request across a busy cycle, and showing through later indirect reads that writes elsewhere leave the FSR alone.

// File: rtl/dmau_pkg.sv
package dmau_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/dmau_addr_mux.sv
module dmau_addr_mux #(
  parameter int ADDR_W        = 8,
  parameter int FILE_W        = 5,
  parameter int INDIRECT_FILE = 0
) (
  input  logic [ADDR_W-1:0] fsr,
  input  logic [FILE_W-1:0] file,
  output logic [ADDR_W-1:0] addr
);
  localparam int BANK_W = ADDR_W - FILE_W;

  logic [ADDR_W-1:0] direct_addr;
  logic              indirect;

  assign direct_addr[FILE_W-1:0] = file;

  genvar g;
  generate
    for (g = 0; g < BANK_W; g++) begin : g_bank
      assign direct_addr[FILE_W+g] = fsr[FILE_W+g];
    end
  endgenerate

  assign indirect = (file == FILE_W'(INDIRECT_FILE));
  assign addr     = indirect ? fsr : direct_addr;
endmodule

// File: rtl/dmau_fsr.sv
module dmau_fsr #(
  parameter int              ADDR_W    = 8,
  parameter int              FILE_W    = 5,
  parameter int              FSR_FILE  = 4,
  parameter logic [ADDR_W-1:0] FSR_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_strobe,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] fsr
);
  logic hit;
  assign hit = wr_strobe && (wr_addr[FILE_W-1:0] == FILE_W'(FSR_FILE));

  always_ff @(posedge clk) begin
    if (!rst_n)   fsr <= FSR_RESET;
    else if (hit) fsr <= wr_data;
  end

  AST_FSR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && wr_addr[FILE_W-1:0] == FILE_W'(FSR_FILE)) |=> fsr == $past(wr_data)); // R9
  AST_FSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe |=> $stable(fsr)); // R10
endmodule

// File: rtl/dmau_seq.sv
module dmau_seq
  import dmau_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              acc_ready,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_oe
);
  phase_e phase, phase_nx;
  logic   accept;

  assign acc_ready = (phase == PH_IDLE);
  assign accept    = acc_valid && acc_ready;

  always_comb begin
    phase_nx = PH_IDLE;
    if (accept) phase_nx = acc_write ? PH_WRITE : PH_READ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      phase <= phase_nx;
      if (accept) begin
        ram_addr <= addr_in;
        if (acc_write) ram_wdata <= wdata_in;
      end
    end
  end

  assign ram_we = (phase == PH_WRITE);
  assign ram_oe = (phase == PH_READ);

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_we && ram_oe)); // R6
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we); // R5
  AST_OE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_oe |=> !ram_oe); // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we || ram_oe) |-> !acc_ready); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && acc_ready) |=> ($stable(ram_addr) && $stable(ram_wdata))); // R8
endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit #(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int FILE_W        = 5,
  parameter int INDIRECT_FILE = 0,
  parameter int FSR_FILE      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic              acc_write,
  input  logic [FILE_W-1:0] acc_file,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ram_we,
  output logic              ram_oe
);
  localparam int BANK_W = ADDR_W - FILE_W;

  logic [ADDR_W-1:0] fsr;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] fsr_wr_data;

  assign fsr_wr_data = ADDR_W'(ram_wdata);

  dmau_addr_mux #(
    .ADDR_W(ADDR_W), .FILE_W(FILE_W), .INDIRECT_FILE(INDIRECT_FILE)
  ) u_mux (
    .fsr(fsr), .file(acc_file), .addr(eff_addr)
  );

  dmau_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write),
    .addr_in(eff_addr), .wdata_in(acc_wdata),
    .acc_ready(acc_ready),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_oe(ram_oe)
  );

  dmau_fsr #(
    .ADDR_W(ADDR_W), .FILE_W(FILE_W), .FSR_FILE(FSR_FILE)
  ) u_fsr (
    .clk(clk), .rst_n(rst_n),
    .wr_strobe(ram_we), .wr_addr(ram_addr), .wr_data(fsr_wr_data),
    .fsr(fsr)
  );

  AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_file != FILE_W'(INDIRECT_FILE)) |=>
      (ram_addr[FILE_W-1:0] == $past(acc_file) &&
       ram_addr[ADDR_W-1:FILE_W] == $past(fsr[ADDR_W-1:FILE_W]))); // R2
  AST_INDIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_file == FILE_W'(INDIRECT_FILE)) |=>
      ram_addr == $past(fsr)); // R3
  AST_ACCEPT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready) |=> (ram_we != ram_oe)); // R4
endmodule

// File: tb/dmem_addr_unit_bench.sv
module dmem_addr_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [4:0] acc_file = '0;
  logic [7:0] acc_wdata = '0;
  logic       acc_ready, ram_we, ram_oe;
  logic [7:0] ram_addr, ram_wdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dmem_addr_unit u_dmem_addr_unit (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_write(acc_write), .acc_file(acc_file), .acc_wdata(acc_wdata),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_oe(ram_oe)
  );

  // Behavioural reference: integers, one pending access at most.
  int  m_fsr, m_addr, m_wdata;
  bit  m_busy, m_we, m_oe, m_indirect;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fsr = 0; m_addr = 0; m_wdata = 0;
      m_busy = 0; m_we = 0; m_oe = 0; m_indirect = 0;
    end else if (m_busy) begin
      if (m_we && (m_addr % 32) == 4) m_fsr = m_wdata;   // R9
      m_busy = 0; m_we = 0; m_oe = 0;
    end else if (acc_valid) begin
      m_indirect = (acc_file == 0);
      m_addr = m_indirect ? m_fsr : (m_fsr / 32) * 32 + int'(acc_file);
      if (acc_write) m_wdata = int'(acc_wdata);
      m_we = acc_write; m_oe = !acc_write; m_busy = 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(ram_addr == m_addr[7:0], m_indirect ? "R3" : "R2", "ram_addr",
            ram_addr, m_addr);
      check(ram_oe == m_oe, "R4", "ram_oe", ram_oe, m_oe);
      check(ram_we == m_we, "R5", "ram_we", ram_we, m_we);
      check(ram_wdata == m_wdata[7:0], "R8", "ram_wdata", ram_wdata, m_wdata);
      check(acc_ready == !m_busy, "R7", "acc_ready", acc_ready, !m_busy);
      check(!(ram_we && ram_oe), "R6", "strobe overlap", ram_we & ram_oe, 0);
    end
  end

  task automatic access(input bit wr, input logic [4:0] f, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = wr; acc_file = f; acc_wdata = d;
    forever begin
      bit r;
      r = acc_ready;
      @(posedge clk);
      if (r) break;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    acc_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // Expect an indirect read to return a given FSR value (observes R9/R10).
  task automatic probe_fsr(input int exp, input string req);
    access(1'b0, 5'd0, 8'h00);
    check(ram_addr == exp[7:0] && ram_oe, req, "FSR via indirect read", ram_addr, exp);
    idle(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ram_we == 0 && ram_oe == 0, "R1", "strobes in reset", {ram_we, ram_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ram_addr == 0 && ram_wdata == 0 && acc_ready, "R1", "reset outputs",
          {ram_addr, ram_wdata, 7'd0, acc_ready}, 1);
    probe_fsr(8'h00, "R1");
    // R2 direct read in bank 0
    access(1'b0, 5'd5, 8'h00); idle(1);
    // R9 direct write to FSR, then new bank bits apply
    access(1'b1, 5'd4, 8'hA3);
    access(1'b0, 5'd7, 8'h00);          // back-to-back: held across busy cycle (R7)
    check(ram_addr == 8'hA7, "R9", "bank after FSR write", ram_addr, 8'hA7);
    idle(1);
    probe_fsr(8'hA3, "R3");
    // R10 write elsewhere leaves FSR alone
    access(1'b1, 5'd9, 8'h55); idle(2);
    probe_fsr(8'hA3, "R10");
    access(1'b1, 5'd0, 8'h3C); idle(1); // indirect write to A3 (not FSR)
    probe_fsr(8'hA3, "R10");
    // FSR mirror in another bank: address A4
    access(1'b1, 5'd4, 8'hE4); idle(1);
    probe_fsr(8'hE4, "R9");
    // Indirect write through pointer aimed at FSR itself
    access(1'b1, 5'd0, 8'h21); idle(1);
    probe_fsr(8'h21, "R9");
    access(1'b0, 5'd31, 8'h00);
    check(ram_addr == 8'h3F, "R2", "bank 1 top file", ram_addr, 8'h3F);
    // Burst of mixed accesses with valid held high
    for (int i = 1; i < 24; i++)
      access(i[0], 5'(i * 3), 8'(i * 17));
    idle(3);
    // Reset mid-stream returns to defaults
    access(1'b1, 5'd4, 8'hC4);
    rst_n = 1'b0; acc_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    probe_fsr(8'h00, "R1");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule